// File: doc/BRIEF.md
# Converter Conversion Sequencer with Auto-Sleep

This block times one successive-approximation conversion of a 10-bit converter. It runs on the internal system clock. It watches an asynchronous active-low start request. A falling edge of that request moves the track/hold into hold and raises a busy flag. The block then walks a bit-trial register from the most significant bit down to bit 0 against a single comparator input. It gives each bit an equal slice of the conversion time. The conversion length depends on the channel address captured at the start. Address 000, the temperature channel, gets the long length. Every other address gets the short length.

When the last bit has been decided, the block releases hold, drops busy and issues a one-cycle valid strobe with the result and the channel address that was used. It also samples the start request at that moment. If the request is still low, the block powers down. It stays powered down until the request rises, and after that it waits out a wake-up time before it accepts another start. If the request is already high, the block stays powered. It then enforces a minimum track (acquisition) time before the next start.

The states are IDLE (powered, tracking), CONV (converting), SLEEP (powered down) and WAKE (power-up delay). The transitions are:
- IDLE to CONV on an accepted start edge.
- CONV to IDLE at the end of the conversion when the request is high.
- CONV to SLEEP at the end of the conversion when the request is low.
- SLEEP to WAKE on a rising edge of the request.
- WAKE to IDLE when the wake-up timer expires.

Top module: `conv_seq`

## Requirements
- R1: After reset, busy, hold and result_valid are 0, pwr_en is 1, and the block is in IDLE, ready to accept a start.
- R2: In IDLE, once the acquisition time has elapsed, a falling edge on start_n raises busy and hold. busy reaches the output on the third rising clock edge after start_n falls, which is within 50 ns.
- R3: busy and hold stay high for exactly LONG_CYC cycles when the channel address captured at the start is 000, and for exactly SHORT_CYC cycles for any other address. Changing chan_sel during a conversion has no effect on the length.
- R4: The result is straight binary, with the most significant bit decided first. Each bit is kept when cmp_hi is 1 for that trial. The first trial code is 1 followed by zeros.
- R5: result_valid is high for exactly one cycle: the first cycle in which busy is low. result_chan then carries the captured address.
- R6: Falling edges of start_n while busy is high are ignored. The conversion length stays the same, and only one valid strobe is issued.
- R7: If start_n is low when the conversion ends, pwr_en drops together with busy and stays low until start_n rises. A falling edge that arrives within WAKE_CYC cycles after that rise is ignored.
- R8: If start_n is high when the conversion ends, pwr_en stays 1.
- R9: A falling edge of start_n that arrives fewer than ACQ_CYC cycles after busy falls starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Asynchronous active-low convert request |
| chan_sel | input | 3 | Channel address; 000 selects the temperature channel |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial code |
| busy | output | 1 | High during a conversion |
| hold | output | 1 | Track/hold control: 1 means hold |
| trial_code | output | 10 | Current bit-trial code driving the DAC |
| result | output | 10 | Last conversion result |
| result_valid | output | 1 | One-cycle strobe when a result is delivered |
| result_chan | output | 3 | Channel address of the delivered result |
| pwr_en | output | 1 | Analog power enable; 0 while powered down |

## Verification
The comparator is modelled as a threshold: it answers 1 whenever the trial code is at or below a target value. The converted codes are therefore known in advance.

The targets are:
- 0 and 1023, which test that no bit is stuck at 1 or stuck at 0.
- 512 and 511, which test the carry across the most significant bit.
- 341 and 682, which use alternating bit patterns to catch swapped or shifted bits.

Short and long channels are interleaved, and the channel is changed during a conversion, so a length taken from the live channel input is exposed. Extra start edges are placed in three windows: during busy, inside the acquisition window, and inside the wake-up delay. Each of these edges must leave the busy output and the valid-strobe count unchanged. Conversions are ended with start_n both low and high, which separates the powered-down path from the stay-powered path.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/start_sync.sv
module start_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level,
    output logic fall,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= async_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign fall  = prev_q & ~sync_q;
    assign rise  = ~prev_q & sync_q;
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int RES_BITS   = 10,
    parameter int STEP_SHORT = 90,
    parameter int STEP_LONG  = 270
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        long_sel,
    output logic                        step_end,
    output logic                        last_step,
    output logic [$clog2(RES_BITS)-1:0] bit_idx
);
    localparam int STEP_MAX = (STEP_LONG > STEP_SHORT) ? STEP_LONG : STEP_SHORT;
    localparam int CNT_W    = $clog2(STEP_MAX + 1);
    localparam int IDX_W    = $clog2(RES_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             long_q;
    logic             run_q;

    assign limit     = long_q ? CNT_W'(STEP_LONG - 1) : CNT_W'(STEP_SHORT - 1);
    assign step_end  = run_q && (cnt_q == limit);
    assign last_step = step_end && (bit_idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_idx <= '0;
            long_q  <= 1'b0;
            run_q   <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            bit_idx <= IDX_W'(RES_BITS - 1);
            long_q  <= long_sel;
            run_q   <= 1'b1;
        end else if (step_end) begin
            cnt_q <= '0;
            if (bit_idx == '0) begin
                run_q <= 1'b0;
            end else begin
                bit_idx <= bit_idx - 1'b1;
            end
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        step_end,
    input  logic [$clog2(RES_BITS)-1:0] bit_idx,
    input  logic                        cmp_hi,
    output logic [RES_BITS-1:0]         trial,
    output logic [RES_BITS-1:0]         decided
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    always_comb begin
        decided = trial;
        for (int i = 0; i < RES_BITS; i++) begin
            if (int'(bit_idx) == i) begin
                decided[i] = cmp_hi;
                if (i > 0) begin
                    decided[i-1] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (start) begin
            trial <= MSB_ONLY;
        end else if (step_end) begin
            trial <= decided;
        end
    end

    a_r4_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (trial == MSB_ONLY));
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int RES_BITS  = 10,
    parameter int CHAN_W    = 3,
    parameter int SHORT_CYC = 900,
    parameter int LONG_CYC  = 2700,
    parameter int WAKE_CYC  = 200,
    parameter int ACQ_CYC   = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_n,
    input  logic [CHAN_W-1:0]   chan_sel,
    input  logic                cmp_hi,
    output logic                busy,
    output logic                hold,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic [CHAN_W-1:0]   result_chan,
    output logic                pwr_en
);
    localparam int STEP_SHORT = SHORT_CYC / RES_BITS;
    localparam int STEP_LONG  = LONG_CYC / RES_BITS;
    localparam int IDX_W      = $clog2(RES_BITS);
    localparam int GAP_MAX    = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
    localparam int GAP_W      = $clog2(GAP_MAX + 1);
    localparam int LEN_W      = $clog2(LONG_CYC + SHORT_CYC + 2);

    seq_state_t state_q, state_d;

    logic             req_level, req_fall, req_rise;
    logic             step_end, last_step;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_BITS-1:0] decided;
    logic             gap_done, gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             conv_go;
    logic [CHAN_W-1:0] chan_q;

    start_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (start_n),
        .level   (req_level),
        .fall    (req_fall),
        .rise    (req_rise)
    );

    step_timer #(
        .RES_BITS   (RES_BITS),
        .STEP_SHORT (STEP_SHORT),
        .STEP_LONG  (STEP_LONG)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (conv_go),
        .long_sel  (chan_sel == '0),
        .step_end  (step_end),
        .last_step (last_step),
        .bit_idx   (bit_idx)
    );

    sar_reg #(
        .RES_BITS (RES_BITS)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_go),
        .step_end (step_end),
        .bit_idx  (bit_idx),
        .cmp_hi   (cmp_hi),
        .trial    (trial_code),
        .decided  (decided)
    );

    gap_timer #(
        .WIDTH (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .done     (gap_done)
    );

    assign conv_go = (state_q == ST_IDLE) && req_fall && gap_done;

    always_comb begin
        gap_load = 1'b0;
        gap_val  = GAP_W'(ACQ_CYC);
        if (state_q == ST_CONV && last_step && req_level) begin
            gap_load = 1'b1;
        end else if (state_q == ST_SLEEP && req_rise) begin
            gap_load = 1'b1;
            gap_val  = GAP_W'(WAKE_CYC);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (conv_go)   state_d = ST_CONV;
            ST_CONV:  if (last_step) state_d = req_level ? ST_IDLE : ST_SLEEP;
            ST_SLEEP: if (req_rise)  state_d = ST_WAKE;
            ST_WAKE:  if (gap_done)  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy   = (state_q == ST_CONV);
        hold   = (state_q == ST_CONV);
        pwr_en = (state_q != ST_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q       <= '0;
            result       <= '0;
            result_valid <= 1'b0;
            result_chan  <= '0;
        end else begin
            result_valid <= 1'b0;
            if (conv_go) begin
                chan_q <= chan_sel;
            end
            if (state_q == ST_CONV && last_step) begin
                result       <= decided;
                result_valid <= 1'b1;
                result_chan  <= chan_q;
            end
        end
    end

    // checking
    logic [LEN_W-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 1'b1;
        else           busy_len_q <= '0;
    end

    a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len_q == ((result_chan == '0) ? LEN_W'(LONG_CYC) : LEN_W'(SHORT_CYC))));

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r5_valid_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_valid);

    a_r7_sleep_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !busy);
endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
    localparam int RES   = 10;
    localparam int SHORT = 900;
    localparam int LONG  = 2700;
    localparam int WAKE  = 200;
    localparam int ACQ   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1;
    logic [2:0] chan_sel = 3'd0;
    logic cmp_hi;
    logic busy, hold, result_valid, pwr_en;
    logic [RES-1:0] trial_code, result;
    logic [2:0] result_chan;
    logic [RES-1:0] vin = '0;

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic [2:0]     ch;
        logic [RES-1:0] val;
        logic [15:0]    len;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    assign cmp_hi = (trial_code <= vin);

    conv_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_n      (start_n),
        .chan_sel     (chan_sel),
        .cmp_hi       (cmp_hi),
        .busy         (busy),
        .hold         (hold),
        .trial_code   (trial_code),
        .result       (result),
        .result_valid (result_valid),
        .result_chan  (result_chan),
        .pwr_en       (pwr_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: busy length, hold tracking, scoreboard pop
    int blen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold !== busy) chk(1'b0, "R3 hold follows busy", hold, busy);
            if (busy) blen++;
            if (result_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected valid strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(result == e.val, "R4 result", result, e.val);
                    chk(result_chan == e.ch, "R5 result_chan", result_chan, e.ch);
                    chk(blen == int'(e.len), "R3 busy length", blen, e.len);
                    chk(!busy, "R5 valid with busy low", busy, 0);
                end
                blen = 0;
            end
        end
    end

    // driver
    task automatic run_conv(input logic [2:0] ch, input logic [RES-1:0] v,
                            input bit stay_low, input bit glitch);
        exp_t e;
        int k;
        chan_sel = ch;
        vin = v;
        e.ch = ch;
        e.val = v;
        e.len = (ch == 3'd0) ? 16'(LONG) : 16'(SHORT);
        sb_q.push_back(e);
        @(negedge clk);
        start_n = 1'b0;
        k = 0;
        while (!busy && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk(k == 3, "R2 start latency", k, 3);
        chan_sel = ~ch;  // R3: must not alter length
        if (glitch) begin
            wait_cyc(100); start_n = 1'b1;
            wait_cyc(20);  start_n = 1'b0;   // R6: ignored while busy
            wait_cyc(20);  start_n = 1'b1;
            wait_cyc(20);  start_n = 1'b0;
            wait_cyc(20);  start_n = 1'b1;
        end else if (!stay_low) begin
            wait_cyc(10);
            start_n = 1'b1;
        end
        k = 0;
        while (busy && k < 5000) begin
            @(negedge clk);
            k++;
        end
        if (stay_low) chk(pwr_en == 1'b0, "R7 powered down", pwr_en, 0);
        else          chk(pwr_en == 1'b1, "R8 stays powered", pwr_en, 1);
    endtask

    task automatic quiet_window(input int n, input string tag);
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk(!seen, tag, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk(busy == 0 && hold == 0, "R1 reset busy/hold", busy, 0);
        chk(result_valid == 0, "R1 reset valid", result_valid, 0);
        chk(pwr_en == 1, "R1 reset pwr_en", pwr_en, 1);
        rst_n = 1'b1;
        wait_cyc(5);

        run_conv(3'd1, 10'd512, 0, 0);
        wait_cyc(60);
        run_conv(3'd0, 10'd1023, 0, 0);
        wait_cyc(60);
        run_conv(3'd3, 10'd0, 0, 1);       // R6 glitches during busy
        wait_cyc(60);

        // R9: early start inside acquisition window
        run_conv(3'd2, 10'd341, 0, 0);
        wait_cyc(5);
        start_n = 1'b0;
        quiet_window(60, "R9 early start ignored");
        start_n = 1'b1;
        wait_cyc(60);

        // R7: power down, wake, ignored start during wake
        run_conv(3'd0, 10'd682, 1, 0);
        wait_cyc(50);
        chk(pwr_en == 0, "R7 stays down while low", pwr_en, 0);
        start_n = 1'b1;
        wait_cyc(4);
        chk(pwr_en == 1, "R7 powers up on rise", pwr_en, 1);
        wait_cyc(20);
        start_n = 1'b0;
        quiet_window(40, "R7 start during wake ignored");
        start_n = 1'b1;
        wait_cyc(WAKE + 20);

        run_conv(3'd4, 10'd511, 0, 0);
        wait_cyc(60);
        run_conv(3'd7, 10'd1, 0, 0);
        wait_cyc(20);

        chk(sb_q.size() == 0, "R5 all results delivered", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule